// File: doc/BRIEF.md
# Replacement-Word Scan Vector Builder

This block rebuilds a sequence of scan test vectors from a compressed stream of replacement words. An external tester, running at its own slow rate, writes words into a small circular buffer. The block drains that buffer at system speed. The current vector is held as a set of equal-width blocks, and each word overwrites exactly one of them. Blocks that no word names keep the value they had in the previous vector, so a vector that differs from its predecessor in only a few blocks costs only a few words.

Each word carries a block index, a new pattern for that block and a last flag. When a word with the last flag set has been applied, the vector is complete. The block then raises a request to a downstream scan applicator and holds the assembled vector steady until the applicator acknowledges it. It consumes no more words until then. A write that arrives while every buffer slot still holds an unread word is refused and latches an error. An end-of-test input finishes the session once every buffered word has been processed and the last vector has been handed off.

Top module: `rw_vector_builder`

## Requirements
- R1: A word of WORD_W bits is split as follows. Bit WORD_W-1 is the last flag. The next IDX_W = clog2(NUM_BLK) bits down are the block index. The low BLK_W = WORD_W-1-IDX_W bits are the pattern. With the defaults (32, 8 blocks) this gives bit 31 as the flag, bits 30:28 as the index and bits 27:0 as the pattern.
- R2: Applying a word stores its pattern in the addressed block. Block i appears on `vec_data[i*BLK_W +: BLK_W]`.
- R3: Blocks that no word of the current vector addresses keep their previous values.
- R4: After reset the following are all zero: every block of `vec_data`, `vec_req`, `done` and `overflow_err`.
- R5: Suppose the buffer was empty and the builder idle. A word with the last flag set that is written at clock edge k raises `vec_req` after edge k+1. `vec_req` stays high until `vec_ack` is sampled high, and it drops after that edge.
- R6: While `vec_req` is high, no buffered word is consumed and `vec_data` does not change.
- R7: Words are consumed in the order written, through a buffer of BUF_DEPTH slots that wraps cyclically. When one block is written twice in a vector, the later word wins.
- R8: A write that arrives when BUF_DEPTH unread words are pending, and no word is consumed in that same cycle, is dropped. It sets `overflow_err`, which stays set until reset. The buffered words are kept intact.
- R9: After `end_test` has been seen, `done` rises once the buffer is empty and no request is pending. If `end_test` arrives while a request is pending, `done` rises one edge after the acknowledging edge. From then on `done` stays high, no word is consumed and `vec_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Tester write strobe for one word |
| wr_word | input | WORD_W | Replacement word from the tester |
| end_test | input | 1 | Marks the end of the test session (latched) |
| vec_req | output | 1 | Assembled vector is ready for the applicator |
| vec_ack | input | 1 | Applicator has taken the vector |
| vec_data | output | NUM_BLK*BLK_W | Current block store, block 0 in the low bits |
| overflow_err | output | 1 | Sticky flag for a refused write to a full buffer |
| done | output | 1 | Session finished and last vector handed off |

## Verification
A word written at edge k is counted in the buffer after edge k and applied at edge k+1. The bench therefore samples at falling edges and expects the store update and `vec_req` one half-cycle after edge k+1. It also checks that `vec_req` is still low at the falling edge just after edge k. An acknowledge sampled at edge e clears `vec_req` by the next falling edge. With end-of-test pending, `done` is checked low at that falling edge and high one cycle later. Overflow is checked on the falling edge right after the refused write, and the refused word's absence is confirmed once the buffered words have built the next vector.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } rwb_state_e;
endpackage

// File: rtl/rwb_field_split.sv
module rwb_field_split #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3,
    localparam int BLK_W = WORD_W - 1 - IDX_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              last,
    output logic [IDX_W-1:0]  idx,
    output logic [BLK_W-1:0]  pat
);
    assign last = word[WORD_W-1];
    assign idx  = word[WORD_W-2 -: IDX_W];
    assign pat  = word[BLK_W-1:0];
endmodule

// File: rtl/rwb_word_ring.sv
module rwb_word_ring #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_word,
    output logic              empty,
    output logic              ovf
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic full, accept, take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full   = (ring_q.cnt == CNT_W'(DEPTH));
        empty  = (ring_q.cnt == '0);
        take   = pop && !empty;
        accept = push && (!full || take);
        ring_d = ring_q;
        if (accept) ring_d.wr = bump(ring_q.wr);
        if (take)   ring_d.rd = bump(ring_q.rd);
        case ({accept, take})
            2'b10:   ring_d.cnt = ring_q.cnt + 1'b1;
            2'b01:   ring_d.cnt = ring_q.cnt - 1'b1;
            default: ring_d.cnt = ring_q.cnt;
        endcase
        if (push && !accept) ring_d.ovf = 1'b1;
    end

    assign pop_word = mem_q[ring_q.rd];
    assign ovf      = ring_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[ring_q.wr] <= push_word;
    end
endmodule

// File: rtl/rwb_block_store.sv
module rwb_block_store #(
    parameter int NUM_BLK = 8,
    parameter int BLK_W   = 28,
    localparam int IDX_W  = $clog2(NUM_BLK)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [BLK_W-1:0]         pat,
    output logic [NUM_BLK*BLK_W-1:0] flat
);
    logic [BLK_W-1:0] blk_d [NUM_BLK];
    logic [BLK_W-1:0] blk_q [NUM_BLK];

    always_comb begin
        for (int i = 0; i < NUM_BLK; i++) begin
            blk_d[i] = (we && (int'(idx) == i)) ? pat : blk_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLK; i++) blk_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BLK; i++) blk_q[i] <= blk_d[i];
        end
    end

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_flat
        assign flat[g*BLK_W +: BLK_W] = blk_q[g];
    end
endmodule

// File: rtl/rw_vector_builder.sv
module rw_vector_builder #(
    parameter int WORD_W    = 32,
    parameter int NUM_BLK   = 8,
    parameter int BUF_DEPTH = 8,
    localparam int IDX_W    = $clog2(NUM_BLK),
    localparam int BLK_W    = WORD_W - 1 - IDX_W,
    localparam int VEC_W    = NUM_BLK * BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              end_test,
    output logic              vec_req,
    input  logic              vec_ack,
    output logic [VEC_W-1:0]  vec_data,
    output logic              overflow_err,
    output logic              done
);
    import rwb_pkg::*;

    typedef struct packed {
        rwb_state_e st;
        logic       end_seen;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] head_word;
    logic              buf_empty;
    logic              pop;
    logic              w_last;
    logic [IDX_W-1:0]  w_idx;
    logic [BLK_W-1:0]  w_pat;

    rwb_word_ring #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_word (wr_word),
        .pop       (pop),
        .pop_word  (head_word),
        .empty     (buf_empty),
        .ovf       (overflow_err)
    );

    rwb_field_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_split (
        .word (head_word),
        .last (w_last),
        .idx  (w_idx),
        .pat  (w_pat)
    );

    rwb_block_store #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pop),
        .idx   (w_idx),
        .pat   (w_pat),
        .flat  (vec_data)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.end_seen = ctl_q.end_seen | end_test;
        pop            = 1'b0;
        case (ctl_q.st)
            ST_RUN: begin
                if (!buf_empty) begin
                    pop = 1'b1;
                    if (w_last) ctl_d.st = ST_WAIT;
                end else if (ctl_q.end_seen) begin
                    ctl_d.st = ST_DONE;
                end
            end
            ST_WAIT: begin
                if (vec_ack) ctl_d.st = ST_RUN;
            end
            default: ctl_d.st = ST_DONE;
        endcase
    end

    assign vec_req = (ctl_q.st == ST_WAIT);
    assign done    = (ctl_q.st == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_RUN, end_seen: 1'b0};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
    parameter int VEC_W = 224
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_req,
    input logic             vec_ack,
    input logic [VEC_W-1:0] vec_data,
    input logic             overflow_err,
    input logic             done
);
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && !vec_ack |=> vec_req);

    p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && vec_ack |=> !vec_req);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && !vec_ack |=> $stable(vec_data));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    p_done_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !vec_req && $stable(vec_data));
endmodule

bind rw_vector_builder rwb_checker #(.VEC_W(VEC_W)) u_rwb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vec_req      (vec_req),
    .vec_ack      (vec_ack),
    .vec_data     (vec_data),
    .overflow_err (overflow_err),
    .done         (done)
);

// File: tb/tb_rw_vector_builder.sv
`timescale 1ns/1ps
module tb_rw_vector_builder;
    localparam int WW = 32;
    localparam int NB = 8;
    localparam int BD = 8;
    localparam int BW = WW - 1 - $clog2(NB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [WW-1:0] wr_word = '0;
    logic end_test = 1'b0;
    logic vec_ack = 1'b0;
    logic vec_req, overflow_err, done;
    logic [NB*BW-1:0] vec_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [BW-1:0] exp_blk [NB];
    logic [BW-1:0] old_blk [NB];

    rw_vector_builder #(.WORD_W(WW), .NUM_BLK(NB), .BUF_DEPTH(BD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .end_test(end_test), .vec_req(vec_req), .vec_ack(vec_ack),
        .vec_data(vec_data), .overflow_err(overflow_err), .done(done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [BW-1:0] mkpat(input int v, input int i);
        return BW'((v * 32'h0123_4567) ^ (i * 32'h0009_ABCD) ^ 32'h5A5);
    endfunction

    // R1 layout: flag at bit 31, index at 30:28, pattern at 27:0
    task automatic drive_word(input bit last, input int idx, input logic [BW-1:0] pat);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_word = {last, 3'(idx), pat};
    endtask

    task automatic put_word(input bit last, input int idx, input logic [BW-1:0] pat);
        drive_word(last, idx, pat);
        exp_blk[idx] = pat;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_blocks(input string tag);
        for (int i = 0; i < NB; i++) begin
            check(vec_data[i*BW +: BW] === exp_blk[i], tag,
                  64'(vec_data[i*BW +: BW]), 64'(exp_blk[i]));
        end
    endtask

    task automatic wait_req();
        for (int i = 0; i < 40; i++) begin
            if (vec_req) break;
            @(negedge clk);
        end
    endtask

    task automatic ack();
        @(negedge clk);
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        check(vec_req == 1'b0, "R5 release after ack", 64'(vec_req), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) exp_blk[i] = '0;
        repeat (3) @(negedge clk);
        // R4 reset state
        check(vec_req == 1'b0, "R4 vec_req", 64'(vec_req), 0);
        check(done == 1'b0, "R4 done", 64'(done), 0);
        check(overflow_err == 1'b0, "R4 overflow_err", 64'(overflow_err), 0);
        check_blocks("R4 store cleared");
        rst_n = 1'b1;

        // Sweep of vectors: R1, R2, R3, R5, R7 (duplicate writes, ring wrap)
        for (int v = 0; v < 12; v++) begin
            int sel [$];
            for (int i = 0; i < NB; i++)
                if (((i * 3 + v) % 4 == 0) || i == (v % NB)) sel.push_back(i);
            if (v % 2 == 1) put_word(1'b0, v % NB, ~mkpat(v, 99));
            for (int j = 0; j < sel.size(); j++)
                put_word(j == sel.size() - 1, sel[j], mkpat(v, sel[j]));
            idle();
            check(vec_req == 1'b0, "R5 not yet raised", 64'(vec_req), 0);
            @(negedge clk);
            check(vec_req == 1'b1, "R5 raised one edge after last word", 64'(vec_req), 1);
            check_blocks("R2/R3/R7 vector contents");
            repeat (3) @(negedge clk);
            check(vec_req == 1'b1, "R5 held without ack", 64'(vec_req), 1);
            ack();
        end

        // R6: words written while a request is pending wait
        put_word(1'b1, 2, mkpat(50, 2));
        idle();
        wait_req();
        for (int i = 0; i < NB; i++) old_blk[i] = exp_blk[i];
        put_word(1'b0, 3, mkpat(51, 3));
        put_word(1'b1, 4, mkpat(51, 4));
        idle();
        repeat (4) @(negedge clk);
        for (int i = 0; i < NB; i++)
            check(vec_data[i*BW +: BW] === old_blk[i], "R6 store frozen during request",
                  64'(vec_data[i*BW +: BW]), 64'(old_blk[i]));
        ack();
        wait_req();
        check(vec_req == 1'b1, "R6 queued vector delivered", 64'(vec_req), 1);
        check_blocks("R6 queued vector contents");
        ack();

        // R8: fill the buffer behind a pending request, then overflow
        put_word(1'b1, 2, mkpat(60, 2));
        idle();
        wait_req();
        for (int i = 1; i < NB; i++) put_word(1'b0, i, mkpat(61, i));
        put_word(1'b1, 1, mkpat(62, 1));
        idle();
        check(overflow_err == 1'b0, "R8 full buffer is not overflow", 64'(overflow_err), 0);
        drive_word(1'b1, 0, 28'hABCDEF0);
        idle();
        check(overflow_err == 1'b1, "R8 overflow flagged", 64'(overflow_err), 1);
        ack();
        wait_req();
        check(vec_req == 1'b1, "R8 buffered words kept", 64'(vec_req), 1);
        check_blocks("R8 refused word absent");
        ack();
        repeat (6) @(negedge clk);
        check(vec_req == 1'b0, "R8 no extra vector", 64'(vec_req), 0);
        check(overflow_err == 1'b1, "R8 overflow sticky", 64'(overflow_err), 1);

        // Reset again: R4
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NB; i++) exp_blk[i] = '0;
        check(overflow_err == 1'b0, "R4 overflow cleared by reset", 64'(overflow_err), 0);
        check(vec_req == 1'b0, "R4 vec_req after reset", 64'(vec_req), 0);
        check_blocks("R4 store cleared again");
        rst_n = 1'b1;

        // R9: end of test while a request is pending
        put_word(1'b1, 5, mkpat(70, 5));
        idle();
        wait_req();
        @(negedge clk);
        end_test = 1'b1;
        @(negedge clk);
        end_test = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R9 done waits for handoff", 64'(done), 0);
        ack();
        check(done == 1'b0, "R9 done not yet", 64'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R9 done one edge after ack", 64'(done), 1);
        drive_word(1'b1, 3, mkpat(71, 3));
        idle();
        repeat (5) @(negedge clk);
        check(vec_req == 1'b0, "R9 no request after done", 64'(vec_req), 0);
        check(done == 1'b1, "R9 done held", 64'(done), 1);
        check_blocks("R9 store untouched after done");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule